// File: doc/BRIEF.md
# Arm-Triggered One-Shot Pulse Timer

This block is a down-counting one-shot timer that produces a single timed pulse. A run is started only by releasing a synchronous arm input: while arm is high the counter keeps reloading from a programmable period register. When arm drops, the count starts. The `pulse` output is high for exactly period+1 enabled clock cycles. The count then stops at zero with the terminal-count output `tc` high. It stays there until the next arm pulse. Neither the enable bit nor reaching terminal count ever reloads or restarts the counter. After power-up the block idles with `tc` low and does not count, even when enable is set.

A controller is built around four named states:
- IDLE: the power-up rest state.
- ARMED: arm is held and the counter is loading.
- RUN: the timed pulse is active.
- DONE: terminal count is held.

The transitions are:
- arm-assert: any state goes to ARMED.
- arm-release: ARMED goes to RUN.
- expire: RUN goes to DONE, when the count is zero and enable is high.
- hold: every other case keeps the current state.

An optional blanking gate passes a downstream `ready_in` signal only while `tc` is high. A second instance can therefore block an early ready indication for a fixed window after it is armed.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset the block is in IDLE with `tc`=0, `pulse`=0 and `count`=0. It stays there, whatever `enable` does, until `arm` is asserted.
- R2: The `enable` input never starts a run. In IDLE or DONE, any sequence of `enable` values leaves `pulse` low and `tc` unchanged.
- R3: While `arm` is high, in any state including mid-run, the block behaves as follows on the next cycle: `tc`=0, `pulse`=0, and `count` equals the period register.
- R4: On the cycle `arm` is sampled low in ARMED, the count reloads from the period register and `pulse` rises. `pulse` then stays high for exactly period+1 enabled cycles, after which `tc` rises in the same cycle that `pulse` falls.
- R5: In DONE, `tc` stays high and `count` stays 0 until `arm` is asserted. Terminal count causes no reload.
- R6: An `arm` pulse of a single clock cycle starts a complete run.
- R7: While `enable` is low during RUN, `count`, `pulse` and `tc` keep their values. The count is not cleared.
- R8: With a period of 0, `pulse` is high for one cycle and `tc` rises on the next.
- R9: `ready_gated` equals `ready_in` AND `tc`, so a ready indication is blocked during IDLE, ARMED and RUN.
- R10: A period write (`period_wr`=1 stores `period_wdata` at the clock edge) affects only later loads. A write during RUN leaves the run in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| arm | input | 1 | Synchronous arm; a run starts when it is released |
| enable | input | 1 | Count enable; freezes the count when low |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | CNT_W | Period value to store |
| ready_in | input | 1 | Downstream ready signal to be blanked |
| tc | output | 1 | Terminal count, high in DONE |
| pulse | output | 1 | Timed pulse, high in RUN |
| count | output | CNT_W | Current count value |
| ready_gated | output | 1 | `ready_in` qualified by `tc` |

## Verification
The hardest situations to reach are re-arming in the middle of a run and freezing the count with enable low while the count is exactly zero in RUN. Random arm pulses rarely land at those moments. Directed sequences therefore re-arm after a fixed number of RUN cycles, and drop enable at chosen counts, including zero. A reference model in the bench follows every random cycle and compares `count`, `tc`, `pulse` and `ready_gated` on every cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } os_state_e;
endpackage

// File: rtl/oneshot_period_reg.sv
module oneshot_period_reg #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] RST_PERIOD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] period
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            period <= RST_PERIOD;
        else if (wr)
            period <= wdata;
    end
endmodule

// File: rtl/oneshot_down_counter.sv
module oneshot_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= count - ONE;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm,
    input  logic      enable,
    input  logic      cnt_zero,
    output os_state_e state,
    output logic      load,
    output logic      dec,
    output logic      tc,
    output logic      pulse
);
    os_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state;
        if (arm) begin
            state_d = ST_ARMED;                 // arm-assert
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_IDLE;    // hold
                ST_ARMED: state_d = ST_RUN;     // arm-release
                ST_RUN:   if (enable && cnt_zero)
                              state_d = ST_DONE; // expire
                ST_DONE:  state_d = ST_DONE;    // hold
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // output decode
    always_comb begin
        load  = arm;
        dec   = 1'b0;
        tc    = 1'b0;
        pulse = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: load = 1'b1;
            ST_RUN: begin
                pulse = 1'b1;
                dec   = enable && !cnt_zero && !arm;
            end
            ST_DONE:  tc = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/oneshot_ready_gate.sv
module oneshot_ready_gate #(
    parameter bit GATE_EN = 1'b1
) (
    input  logic ready_in,
    input  logic tc,
    output logic ready_out
);
    generate
        if (GATE_EN) begin : g_blank
            assign ready_out = ready_in & tc;
        end else begin : g_pass
            logic unused_tc;
            assign unused_tc = tc;
            assign ready_out = ready_in;
        end
    endgenerate
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter bit GATE_EN = 1'b1,
    parameter logic [CNT_W-1:0] RST_PERIOD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             enable,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             ready_in,
    output logic             tc,
    output logic             pulse,
    output logic [CNT_W-1:0] count,
    output logic             ready_gated
);
    logic [CNT_W-1:0] period_q;
    logic             load, dec, cnt_zero;
    os_state_e        state;

    oneshot_period_reg #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_period (
        .clk(clk), .rst_n(rst_n), .wr(period_wr), .wdata(period_wdata),
        .period(period_q)
    );

    oneshot_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
        .load_val(period_q), .count(count), .zero(cnt_zero)
    );

    oneshot_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .enable(enable),
        .cnt_zero(cnt_zero), .state(state), .load(load), .dec(dec),
        .tc(tc), .pulse(pulse)
    );

    oneshot_ready_gate #(.GATE_EN(GATE_EN)) u_gate (
        .ready_in(ready_in), .tc(tc), .ready_out(ready_gated)
    );
endmodule

// File: rtl/oneshot_pulse_timer_sva.sv
module oneshot_pulse_timer_sva #(
    parameter int CNT_W = 8,
    parameter bit GATE_EN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             enable,
    input logic             tc,
    input logic             pulse,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period_q,
    input logic             ready_in,
    input logic             ready_gated
);
    assert_arm_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!tc && !pulse && count == $past(period_q)));

    assert_no_self_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !$past(arm) && !pulse) |=> !pulse);

    assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && enable && !arm && count == '0) |=> (tc && !pulse));

    assert_tc_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tc, pulse}));

    assert_tc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !arm) |=> (tc && count == '0));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !enable && !arm) |=> ($stable(count) && pulse));

    generate
        if (GATE_EN) begin : g_gate_chk
            assert_ready_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ready_gated |-> (tc && ready_in));
        end
    endgenerate
endmodule

bind oneshot_pulse_timer oneshot_pulse_timer_sva #(.CNT_W(CNT_W), .GATE_EN(GATE_EN)) u_sva (
    .clk(clk), .rst_n(rst_n), .arm(arm), .enable(enable), .tc(tc),
    .pulse(pulse), .count(count), .period_q(period_q),
    .ready_in(ready_in), .ready_gated(ready_gated)
);

// File: tb/oneshot_pulse_timer_bench.sv
`timescale 1ns/1ps
module oneshot_pulse_timer_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm = 1'b0;
    logic         enable = 1'b0;
    logic         period_wr = 1'b0;
    logic [W-1:0] period_wdata = '0;
    logic         ready_in = 1'b0;
    logic         tc, pulse, ready_gated;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: 0 idle, 1 armed, 2 run, 3 done
    int           m_st = 0;
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_per = '0;

    always #5 clk = ~clk;

    oneshot_pulse_timer #(.CNT_W(W)) u_oneshot_pulse_timer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .enable(enable),
        .period_wr(period_wr), .period_wdata(period_wdata),
        .ready_in(ready_in), .tc(tc), .pulse(pulse), .count(count),
        .ready_gated(ready_gated)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_gate(input int st, input bit rdy);
        return rdy && (st == 3);
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_cnt = '0; m_per = '0;
        end else begin
            if (arm) begin
                m_st = 1; m_cnt = m_per;
            end else if (m_st == 1) begin
                m_st = 2; m_cnt = m_per;
            end else if (m_st == 2 && enable) begin
                if (m_cnt == 0) m_st = 3;
                else m_cnt = m_cnt - 1'b1;
            end
            if (period_wr) m_per = period_wdata;
        end
    endtask

    task automatic compare();
        chk(tc == (m_st == 3), "R4 tc", int'(tc), int'(m_st == 3));
        chk(pulse == (m_st == 2), "R4 pulse", int'(pulse), int'(m_st == 2));
        chk(count == m_cnt, "R7 count", int'(count), int'(m_cnt));
        chk(ready_gated == exp_gate(m_st, ready_in), "R9 ready_gated",
            int'(ready_gated), int'(exp_gate(m_st, ready_in)));
    endtask

    task automatic cyc(input bit a, input bit e, input bit wr, input logic [W-1:0] wd, input bit rdy);
        arm = a; enable = e; period_wr = wr; period_wdata = wd; ready_in = rdy;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic set_period(input logic [W-1:0] p);
        cyc(1'b0, 1'b1, 1'b1, p, 1'b0);
    endtask

    // release arm and count pulse cycles until tc
    task automatic measure(output int width);
        width = 0;
        for (int i = 0; i < 400; i++) begin
            cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
            if (pulse) width++;
            if (tc) break;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        void'($urandom(32'd4242));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        chk(!tc && !pulse && count == 0, "R1 reset idle", int'({tc, pulse}), 0);
        // R1/R2: enable high does not start
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk(!tc && !pulse, "R2 enable alone idle", int'({tc, pulse}), 0);

        // R6/R4: single-cycle arm, period 3 -> 4 cycle pulse
        set_period(8'd3);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        measure(w);
        chk(w == 4, "R6 single arm width", w, 4);
        // R5: stays done, no reload
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk(tc && count == 0, "R5 tc held", int'(count), 0);
        // R9: ready passes in DONE
        chk(ready_gated == 1'b1, "R9 ready in done", int'(ready_gated), 1);
        // R2: toggling enable does not retrigger
        for (int i = 0; i < 8; i++) cyc(1'b0, i[0], 1'b0, '0, 1'b0);
        chk(tc && !pulse, "R2 enable toggle no retrigger", int'(pulse), 0);

        // R8: period zero
        set_period(8'd0);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        measure(w);
        chk(w == 1, "R8 zero period width", w, 1);

        // R3: re-arm mid run holds reload value
        set_period(8'd5);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk(ready_gated == 1'b0, "R9 ready blocked in run", int'(ready_gated), 0);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        chk(count == 5 && !tc && !pulse, "R3 arm mid-run", int'(count), 5);
        measure(w);
        chk(w == 6, "R3 restart full width", w, 6);

        // R7: enable low mid-run freezes, including at count zero
        set_period(8'd4);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
        chk(count == 3 && pulse, "R7 freeze mid-run", int'(count), 3);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
        chk(count == 0 && pulse && !tc, "R7 freeze at zero", int'({pulse, tc}), 2);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        chk(tc, "R4 expire after unfreeze", int'(tc), 1);

        // R10: write during run does not disturb it
        set_period(8'd4);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 8'd9, 1'b0);
        w = 2;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
            if (pulse) w++;
            if (tc) break;
        end
        chk(w == 5, "R10 write in run ignored", w, 5);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
        measure(w);
        chk(w == 10, "R10 new period next arm", w, 10);

        // random phase, checked against model every cycle
        for (int i = 0; i < 3000; i++) begin
            bit a, e, wr, rdy;
            a   = ($urandom_range(0, 19) == 0);
            e   = ($urandom_range(0, 5) != 0);
            wr  = ($urandom_range(0, 29) == 0);
            rdy = $urandom_range(0, 1) == 1;
            cyc(a, e, wr, W'($urandom_range(0, 12)), rdy);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule